// File: doc/BRIEF.md
# Shift-Add Fixed-Point Exponential Engine

This block computes e raised to a signed fixed-point argument using only shifts, adds and compares; it has no multiplier. The argument is a two's-complement word with 16 fractional bits (value = word / 65536). The result is an unsigned word with the same 16-bit fractional scaling, and its width is a parameter. The result register starts at 1.0 and the magnitude of the argument goes into a residual register. The engine then walks a short table of logarithm constants. Whenever the current constant fits in the residual, it is subtracted and the result is scaled by the matching factor. The sign of the argument picks one of two tables. Positive arguments use factors 256, 16, 4, 2 and then 1+2^-n, so the scaling is a left shift or y + (y >> n). Negative arguments use 1/256, 1/16, 1/4, 1/2 and then 1-2^-n, so the scaling is a right shift or y - (y >> n).

When the table is exhausted, a small residual r is left over. An optional final step (parameter `USE_CORR`, on by default) applies the first-order term y·(1 ± r) through a short shift-add sum over the bits of r. Internally the result keeps `GUARD` extra fractional bits so that repeated right shifts do not lose precision. A result too large for the output width saturates to all ones. Very negative arguments underflow to zero.

A caller pulses `start` with the argument while the engine is idle. It then waits for the one-cycle `valid` pulse. The result stays on `y_out` until the next completion. One table step takes one clock cycle, so latency grows with the magnitude of the argument: roughly |x|/5.55 cycles plus a few dozen.

Top module: `shadd_exp`

## Requirements
- R1: While reset is asserted and after it is released, `busy` and `valid` are 0 and `y_out` is 0 until the first completion.
- R2: A `start` pulse seen while `busy` is 0 makes `busy` 1 from the next cycle. Completion is marked by `valid` high for exactly one cycle, and `busy` is 0 in that same cycle.
- R3: For a positive argument `x_in` (two's complement, bits [15:0] fractional), `y_out` equals exp(x)·65536 within 0.1 % relative plus 2 LSB, as long as that value is below 2^OUT_W.
- R4: For a negative argument, `y_out` equals exp(x)·65536 within 0.1 % relative plus 2 LSB.
- R5: An argument of 0 gives exactly 65536. An argument of +1 LSB gives exactly 65537.
- R6: When exp(x)·65536 is at least 2^OUT_W, `y_out` is all ones. This includes the largest positive input word.
- R7: An argument of -60.0 or below, including the most negative input word, gives exactly 0.
- R8: A `start` pulse while `busy` is 1 is ignored. The running computation finishes with the result for the argument it accepted.
- R9: `y_out` changes only in a cycle in which `valid` is 1, and it holds its value between completions.
- R10: At the range limits +50.0 and -50.0, the result meets the tolerance of R3 and R4 with the default `OUT_W` of 90.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Begin a computation on `x_in` (taken only while idle) |
| x_in | input | IN_W | Signed argument, 16 fractional bits |
| busy | output | 1 | Computation in progress |
| valid | output | 1 | One-cycle completion pulse |
| y_out | output | OUT_W | Unsigned result, 16 fractional bits, saturating |

## Verification
A wrong table constant or scaling shift appears at the ports as a relative error in the result. That error grows with the number of times the faulty entry is used, so comparing against a real-valued exponential across both signs exposes it on the first affected completion. A residual or index that fails to advance shows up as a missing `valid` pulse. A lost saturation or underflow path shows up as a wrapped value at the range extremes. A fault in the handshake or output register shows up within a cycle or two of `start` or of completion, as a wrong `busy` level, a stretched `valid`, or `y_out` moving while no completion is signalled.

// File: rtl/shadd_exp_pkg.sv
package shadd_exp_pkg;

  // Fractional bits of the argument and of the result.
  localparam int unsigned FRAC_BITS   = 16;
  // Number of entries in each constant table.
  localparam int unsigned TBL_LEN     = 11;
  localparam int unsigned IDX_W       = $clog2(TBL_LEN);
  // Entries that scale by a pure power of two.
  localparam int unsigned SHIFT_STEPS = 4;
  // Width of a stored constant (largest is ln 256 in Q16).
  localparam int unsigned K_W         = 19;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_CORR = 2'd2
  } st_e;

  // ln of the growth factor, Q16, rounded.
  function automatic logic [K_W-1:0] grow_const(input logic [IDX_W-1:0] i);
    case (i)
      IDX_W'(0):  return K_W'(363409);  // 256
      IDX_W'(1):  return K_W'(181704);  // 16
      IDX_W'(2):  return K_W'(90852);   // 4
      IDX_W'(3):  return K_W'(45426);   // 2
      IDX_W'(4):  return K_W'(26573);   // 1 + 1/2
      IDX_W'(5):  return K_W'(14624);   // 1 + 1/4
      IDX_W'(6):  return K_W'(7719);    // 1 + 1/8
      IDX_W'(7):  return K_W'(3973);    // 1 + 1/16
      IDX_W'(8):  return K_W'(2017);    // 1 + 1/32
      IDX_W'(9):  return K_W'(1016);    // 1 + 1/64
      IDX_W'(10): return K_W'(510);     // 1 + 1/128
      default:    return '0;
    endcase
  endfunction

  // -ln of the shrink factor, Q16, rounded.
  function automatic logic [K_W-1:0] shrink_const(input logic [IDX_W-1:0] i);
    case (i)
      IDX_W'(0):  return K_W'(363409);  // 1/256
      IDX_W'(1):  return K_W'(181704);  // 1/16
      IDX_W'(2):  return K_W'(90852);   // 1/4
      IDX_W'(3):  return K_W'(45426);   // 1/2
      IDX_W'(4):  return K_W'(18854);   // 1 - 1/4
      IDX_W'(5):  return K_W'(8751);    // 1 - 1/8
      IDX_W'(6):  return K_W'(4230);    // 1 - 1/16
      IDX_W'(7):  return K_W'(2081);    // 1 - 1/32
      IDX_W'(8):  return K_W'(1032);    // 1 - 1/64
      IDX_W'(9):  return K_W'(514);     // 1 - 1/128
      IDX_W'(10): return K_W'(257);     // 1 - 1/256
      default:    return '0;
    endcase
  endfunction

endpackage

// File: rtl/shadd_exp_rstsync.sv
module shadd_exp_rstsync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/shadd_exp_const.sv
module shadd_exp_const
  import shadd_exp_pkg::*;
(
  input  logic             neg,
  input  logic [IDX_W-1:0] idx,
  output logic [K_W-1:0]   k
);

  always_comb begin
    if (neg) begin
      k = shrink_const(idx);
    end else begin
      k = grow_const(idx);
    end
  end

endmodule

// File: rtl/shadd_exp_scale.sv
module shadd_exp_scale
  import shadd_exp_pkg::*;
#(
  parameter int unsigned ACC_W     = 114,
  parameter int unsigned CORR_BITS = 10,
  parameter int unsigned USE_CORR  = 1
) (
  input  logic [ACC_W-1:0]     y,
  input  logic                 neg,
  input  logic [IDX_W-1:0]     idx,
  input  logic [CORR_BITS-1:0] rlo,
  output logic [ACC_W-1:0]     y_step,
  output logic [ACC_W-1:0]     y_fix
);

  logic [IDX_W-1:0] pow_amt;
  logic [IDX_W-1:0] fine_amt;

  // Power-of-two entries: 8,4,2,1 bit shifts for indices 0..3.
  assign pow_amt  = IDX_W'(8) >> idx[1:0];
  // 1 +/- 2^-n entries: n starts at 1 (grow) or 2 (shrink) at index 4.
  assign fine_amt = neg ? (idx - IDX_W'(2)) : (idx - IDX_W'(3));

  always_comb begin
    if (idx < IDX_W'(SHIFT_STEPS)) begin
      y_step = neg ? (y >> pow_amt) : (y << pow_amt);
    end else begin
      y_step = neg ? (y - (y >> fine_amt)) : (y + (y >> fine_amt));
    end
  end

  generate
    if (USE_CORR != 0) begin : g_corr
      logic [ACC_W-1:0] prod;
      // y * r / 2^FRAC_BITS built from the set bits of the residual.
      always_comb begin
        prod = '0;
        for (int j = 0; j < CORR_BITS; j++) begin
          if (rlo[j]) begin
            prod = prod + (y >> (FRAC_BITS - j));
          end
        end
      end
      assign y_fix = neg ? (y - prod) : (y + prod);
    end else begin : g_nocorr
      assign y_fix = y;
    end
  endgenerate

endmodule

// File: rtl/shadd_exp.sv
module shadd_exp
  import shadd_exp_pkg::*;
#(
  parameter int unsigned IN_W      = 32,
  parameter int unsigned OUT_W     = 90,
  parameter int unsigned GUARD     = 16,
  parameter int unsigned CORR_BITS = 10,
  parameter int unsigned USE_CORR  = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [IN_W-1:0]  x_in,
  output logic             busy,
  output logic             valid,
  output logic [OUT_W-1:0] y_out
);

  // Result register: OUT_W visible bits, GUARD extra fraction bits, and
  // 8 headroom bits for one x256 step beyond the visible range.
  localparam int unsigned HEAD_LO = OUT_W + GUARD;
  localparam int unsigned ACC_W   = HEAD_LO + 8;
  localparam logic [ACC_W-1:0] ACC_ONE = {{(ACC_W-1){1'b0}}, 1'b1} << (FRAC_BITS + GUARD);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(TBL_LEN - 1);

  logic rst_i;

  st_e              st_q, st_d;
  logic [IN_W-1:0]  res_q, res_d;
  logic [ACC_W-1:0] y_q, y_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             neg_q, neg_d;
  logic [OUT_W-1:0] out_q, out_d;
  logic             vld_q, vld_d;
  logic             dp_en;

  logic [IN_W-1:0]  mag;
  logic [K_W-1:0]   k_cur;
  logic [IN_W-1:0]  k_ext;
  logic             fits;
  logic [ACC_W-1:0] y_step;
  logic [ACC_W-1:0] y_fix;
  logic             ovf_step;
  logic             ovf_fix;

  shadd_exp_rstsync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_i)
  );

  shadd_exp_const u_const (
    .neg (neg_q),
    .idx (idx_q),
    .k   (k_cur)
  );

  shadd_exp_scale #(
    .ACC_W     (ACC_W),
    .CORR_BITS (CORR_BITS),
    .USE_CORR  (USE_CORR)
  ) u_scale (
    .y      (y_q),
    .neg    (neg_q),
    .idx    (idx_q),
    .rlo    (res_q[CORR_BITS-1:0]),
    .y_step (y_step),
    .y_fix  (y_fix)
  );

  assign mag      = x_in[IN_W-1] ? (~x_in + IN_W'(1)) : x_in;
  assign k_ext    = {{(IN_W-K_W){1'b0}}, k_cur};
  assign fits     = (res_q >= k_ext);
  assign ovf_step = |y_step[ACC_W-1:HEAD_LO];
  assign ovf_fix  = |y_fix[ACC_W-1:HEAD_LO];
  assign dp_en    = (st_q != ST_IDLE) || start;

  // Next-state logic
  always_comb begin
    st_d  = st_q;
    res_d = res_q;
    y_d   = y_q;
    idx_d = idx_q;
    neg_d = neg_q;
    out_d = out_q;
    vld_d = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (start) begin
          st_d  = ST_RUN;
          neg_d = x_in[IN_W-1];
          res_d = mag;
          y_d   = ACC_ONE;
          idx_d = '0;
        end
      end
      ST_RUN: begin
        if (fits) begin
          // Greedy: stay on this entry while it still fits.
          res_d = res_q - k_ext;
          if (ovf_step) begin
            out_d = '1;
            vld_d = 1'b1;
            st_d  = ST_IDLE;
          end else begin
            y_d = y_step;
          end
        end else if (idx_q == IDX_LAST) begin
          if (USE_CORR != 0) begin
            st_d = ST_CORR;
          end else begin
            out_d = y_q[HEAD_LO-1:GUARD];
            vld_d = 1'b1;
            st_d  = ST_IDLE;
          end
        end else begin
          idx_d = idx_q + IDX_W'(1);
        end
      end
      ST_CORR: begin
        out_d = ovf_fix ? '1 : y_fix[HEAD_LO-1:GUARD];
        y_d   = y_fix;
        vld_d = 1'b1;
        st_d  = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  // Registers
  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      st_q  <= ST_IDLE;
      res_q <= '0;
      y_q   <= '0;
      idx_q <= '0;
      neg_q <= 1'b0;
      out_q <= '0;
      vld_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      vld_q <= vld_d;
      if (dp_en) begin
        res_q <= res_d;
        y_q   <= y_d;
        idx_q <= idx_d;
        neg_q <= neg_d;
      end
      if (vld_d) begin
        out_q <= out_d;
      end
    end
  end

  assign busy  = (st_q != ST_IDLE);
  assign valid = vld_q;
  assign y_out = out_q;

endmodule

// File: rtl/shadd_exp_chk.sv
module shadd_exp_chk #(
  parameter int unsigned OUT_W = 90
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             busy,
  input logic             valid,
  input logic [OUT_W-1:0] y_out
);

  // R2: completion never overlaps a running computation
  p_done_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> !busy);

  // R2: completion marker lasts one cycle
  p_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    valid |=> !valid);

  // R2: an idle start is accepted
  p_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start) |=> busy);

  // R2: a completion is preceded by a running cycle
  p_from_run_r2: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> $past(busy));

  // R9: the result only moves with a completion
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(y_out) |-> valid);

endmodule

bind shadd_exp shadd_exp_chk #(.OUT_W(OUT_W)) u_chk (
  .clk   (clk),
  .rst_n (rst_i),
  .start (start),
  .busy  (busy),
  .valid (valid),
  .y_out (y_out)
);

// File: tb/shadd_exp_test.sv
module shadd_exp_test;

  localparam int  CLK_PERIOD = 10;
  localparam int  IN_W       = 32;
  localparam int  OUT_W      = 90;
  localparam int  ONE        = 65536;
  localparam real REL_TOL    = 1.0e-3;
  localparam real ABS_TOL    = 2.0;

  logic             clk;
  logic             rst_n;
  logic             start;
  logic [IN_W-1:0]  x_in;
  logic             busy;
  logic             valid;
  logic [OUT_W-1:0] y_out;

  int checks = 0;
  int errors = 0;
  int cyc    = 0;

  shadd_exp #(.IN_W(IN_W), .OUT_W(OUT_W)) uut (
    .clk   (clk),
    .rst_n (rst_n),
    .start (start),
    .x_in  (x_in),
    .busy  (busy),
    .valid (valid),
    .y_out (y_out)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      errors = errors + 1;
      $display("FAIL watchdog: run did not finish (actual %0d cycles, expected < 150000)", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  function automatic real to_real(input logic [OUT_W-1:0] v);
    real r = 0.0;
    for (int i = OUT_W - 1; i >= 0; i--) r = r * 2.0 + (v[i] ? 1.0 : 0.0);
    return r;
  endfunction

  function automatic real ref_exp(input int x);
    return $exp(real'(x) / 65536.0) * 65536.0;
  endfunction

  task automatic expect_bit(input string tag, input logic act, input logic exp_v);
    checks++;
    if (act !== exp_v) begin
      errors++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp_v);
    end
  endtask

  task automatic expect_exact(input string tag, input logic [OUT_W-1:0] act,
                              input logic [OUT_W-1:0] exp_v);
    checks++;
    if (act !== exp_v) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp_v);
    end
  endtask

  task automatic expect_exp(input string tag, input int x, input logic [OUT_W-1:0] got);
    real e;
    real a;
    real tol;
    e = ref_exp(x);
    checks++;
    if (e >= 2.0 ** OUT_W) begin
      if (got !== '1) begin
        errors++;
        $display("FAIL %s x=%0d: actual %h expected all ones", tag, x, got);
      end
    end else begin
      a   = to_real(got);
      tol = e * REL_TOL + ABS_TOL;
      if ((a - e > tol) || (e - a > tol)) begin
        errors++;
        $display("FAIL %s x=%0d: actual %g expected %g", tag, x, a, e);
      end
    end
  endtask

  // Start one computation and wait for its completion; samples at negedge.
  task automatic run_one(input int x, output logic [OUT_W-1:0] got, output bit ok);
    int n;
    @(negedge clk);
    start = 1'b1;
    x_in  = x;
    @(negedge clk);
    start = 1'b0;
    n = 0;
    while (!valid && n < 20000) begin
      @(negedge clk);
      n++;
    end
    ok  = valid;
    got = y_out;
    if (!ok) begin
      checks++;
      errors++;
      $display("FAIL R2 x=%0d: actual no valid expected valid pulse", x);
    end
  endtask

  task automatic run_check(input string tag, input int x);
    logic [OUT_W-1:0] got;
    bit ok;
    run_one(x, got, ok);
    if (ok) expect_exp(tag, x, got);
  endtask

  initial begin
    logic [OUT_W-1:0] got;
    logic [OUT_W-1:0] held;
    bit ok;
    int n;
    int seed_dummy;

    rst_n = 1'b0;
    start = 1'b0;
    x_in  = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    expect_bit("R1 busy in reset", busy, 1'b0);
    expect_bit("R1 valid in reset", valid, 1'b0);
    expect_exact("R1 y_out in reset", y_out, '0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    expect_bit("R1 busy after reset", busy, 1'b0);
    expect_exact("R1 y_out after reset", y_out, '0);

    // R2: handshake timing
    @(negedge clk);
    start = 1'b1;
    x_in  = 32'(ONE);
    @(negedge clk);
    start = 1'b0;
    expect_bit("R2 busy after start", busy, 1'b1);
    n = 0;
    while (!valid && n < 20000) begin
      @(negedge clk);
      n++;
    end
    expect_bit("R2 valid pulse", valid, 1'b1);
    expect_bit("R2 busy low at valid", busy, 1'b0);
    expect_exp("R3 x=1.0", ONE, y_out);
    @(negedge clk);
    expect_bit("R2 valid one cycle", valid, 1'b0);

    // R5: exact small cases
    run_one(0, got, ok);
    expect_exact("R5 x=0", got, OUT_W'(65536));
    run_one(1, got, ok);
    expect_exact("R5 x=+1 LSB", got, OUT_W'(65537));

    // R10: range limits
    run_check("R10 x=+50", 50 * ONE);
    run_check("R10 x=-50", -50 * ONE);

    // R3 / R4 directed
    run_check("R3 x=0.5", ONE / 2);
    run_check("R3 x=5.5452", 363409);
    run_check("R3 x=20.3", 1330381);
    run_check("R4 x=-1.0", -ONE);
    run_check("R4 x=-0.001", -66);
    run_check("R4 x=-7.25", -475136);

    // R6: saturation
    run_one(52 * ONE, got, ok);
    expect_exact("R6 x=52", got, '1);
    run_one(32'h7FFF_FFFF, got, ok);
    expect_exact("R6 max input", got, '1);

    // R7: underflow
    run_one(-60 * ONE, got, ok);
    expect_exact("R7 x=-60", got, '0);
    run_one(int'(32'h8000_0000), got, ok);
    expect_exact("R7 min input", got, '0);

    // R8: start while busy is ignored
    @(negedge clk);
    start = 1'b1;
    x_in  = 32'(2 * ONE);
    @(negedge clk);
    x_in  = 32'(-3 * ONE);
    @(negedge clk);
    start = 1'b0;
    n = 0;
    while (!valid && n < 20000) begin
      @(negedge clk);
      n++;
    end
    expect_exp("R8 ignored start", 2 * ONE, y_out);
    expect_bit("R8 idle after first result", busy, 1'b0);

    // R9: output holds between completions
    held = y_out;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      expect_exact("R9 hold", y_out, held);
    end

    // R3 / R4 random
    seed_dummy = $urandom(32'd20240611);
    for (int i = 0; i < 60; i++) begin
      int x;
      x = int'($urandom % 32'(100 * ONE + 1)) - 50 * ONE;
      if (x >= 0) run_check("R3 random", x);
      else        run_check("R4 random", x);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule